// File: doc/BRIEF.md
# DMA Stream Transfer Sequencer

This block sequences one DMA stream. It tracks how many items are left to move and which memory buffer is in use, produces the current memory and peripheral addresses, and keeps the stream's event flags. The bus master, the FIFO and the arbitration sit outside it. Each finished item arrives as a one-cycle `item_done` strobe. When the peripheral controls the length, the end of the transfer arrives as a `per_end` strobe.

Software programs the stream through a small write-only configuration port. It selects the mode (normal, circular or double-buffer), the flow controller (DMA or peripheral), the data size, the address increments, the item count and the base addresses. It then sets the enable bit. The stream runs until its count expires, the peripheral ends it, a bus error stops it, or software clears the enable bit. Five sticky flags are ORed into a single interrupt line.

Reset is asserted asynchronously and released synchronously inside the block, two clock edges after `rst_n` rises. All outputs are registered, so they change on the clock edge after the input that causes them.

Top module: `dma_stream_seq`

## Requirements
- R1: The configuration port writes one register per cycle, selected by `cfg_sel`:
  - 0: control. Bit 0 is enable. Bits 2:1 are the mode: 0 normal, 1 circular, 2 double-buffer, 3 behaves as normal. Bit 3 is the flow controller: 0 DMA, 1 peripheral. Bits 5:4 are the size: 0 one byte, 1 two bytes, 2 or 3 four bytes. Bit 6 is the memory increment. Bit 7 is the peripheral increment.
  - 1: item count.
  - 2: memory base A.
  - 3: memory base B.
  - 4: peripheral base.
  - 5: flag clear.
- R2: Setting the enable bit while idle starts the stream. `remaining` loads the count, `buf_sel` goes to 0, `mem_addr` loads base A and `per_addr` loads the peripheral base. While the stream is active, the control, count and peripheral-base registers are locked; writing control with bit 0 at 0 stops the stream.
- R3: In DMA flow, each `item_done` lowers `remaining` by one. It also advances each address whose increment bit is set by 1, 2 or 4 bytes according to the size; an address whose increment bit is clear stays fixed.
- R4: In normal mode, the last item sets the transfer-complete flag and clears the active state. `remaining` ends at 0 and the addresses keep their last values.
- R5: In circular mode, the last item sets transfer complete, reloads `remaining` and both addresses from the same buffer, and stays active.
- R6: In double-buffer mode, the last item sets transfer complete, toggles `buf_sel`, reloads `remaining`, and loads `mem_addr` from the newly selected base. While the stream is active, only the base register of the buffer not in use accepts writes.
- R7: The half-transfer flag sets on the item after which `remaining` equals the programmed count shifted right by one.
- R8: In peripheral flow, `item_done` advances the addresses but leaves `remaining` at the programmed count. A `per_end` while active sets transfer complete and stops the stream. In DMA flow, `per_end` has no effect.
- R9: A count of zero is rejected, and the transfer-error flag is set, in two cases:
  - enabling in DMA flow with a zero count, in which case the stream stays idle;
  - writing zero to the count register while the stream is active, in which case the count is unchanged.
- R10: A `bus_err` pulse while active sets the transfer-error flag and stops the stream. `fifo_err` sets the FIFO-error flag and `dm_err` sets the direct-mode-error flag.
- R11: The flag bits are: 0 half transfer, 1 transfer complete, 2 transfer error, 3 FIFO error, 4 direct-mode error. Flags stay set until a 1 is written to the same bit of the clear register. A set and a clear of the same bit in the same cycle leave it set.
- R12: `irq` is high exactly when at least one flag is set.
- R13: `item_done` while idle changes neither `remaining` nor the addresses.
- R14: After reset, the stream is idle, `buf_sel`, `remaining`, both addresses and all flags are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | AW (32) | Configuration write data |
| item_done | input | 1 | One item transferred |
| per_end | input | 1 | Peripheral end of transfer |
| bus_err | input | 1 | Bus error on a transfer |
| fifo_err | input | 1 | FIFO error event |
| dm_err | input | 1 | Direct-mode error event |
| active | output | 1 | Stream enabled |
| buf_sel | output | 1 | Memory buffer in use (0 = A, 1 = B) |
| mem_addr | output | AW (32) | Current memory address |
| per_addr | output | AW (32) | Current peripheral address |
| remaining | output | CW (16) | Items left in the current pass |
| flags | output | 5 | Sticky event flags |
| irq | output | 1 | OR of all flags |

## Verification
On every cycle, the assertions check that:
- in DMA flow, `remaining` is never zero while the stream is active;
- an item step lowers `remaining` by exactly one;
- the last item stops, reloads or swaps the buffer as the mode dictates;
- a peripheral end stops the stream;
- an idle stream holds its count;
- flags never drop without a configuration write.

Only the bench scenarios can show the exact address arithmetic for each size and increment setting, the half-transfer point, the rejection of zero counts, the write protection of the in-use buffer base, and set-over-clear priority.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CIRC   = 2'd1,
    MODE_DBUF   = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  // Packed so that it lines up with control bits 7:1
  typedef struct packed {
    logic       pinc;
    logic       minc;
    logic [1:0] size;
    logic       per_flow;
    mode_e      mode;
  } ctrl_t;

  localparam int unsigned NFLAG   = 5;
  localparam int unsigned FL_HALF = 0;
  localparam int unsigned FL_DONE = 1;
  localparam int unsigned FL_TERR = 2;
  localparam int unsigned FL_FERR = 3;
  localparam int unsigned FL_DERR = 4;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_BASEA = 3'd2;
  localparam logic [2:0] SEL_BASEB = 3'd3;
  localparam logic [2:0] SEL_PBASE = 3'd4;
  localparam logic [2:0] SEL_CLEAR = 3'd5;

  localparam int unsigned NPTR = 2;

endpackage

// File: rtl/dss_cfg.sv
module dss_cfg
  import dss_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [AW-1:0]    wdata,
  input  logic             active,
  input  logic             buf_sel,
  output ctrl_t            ctrl_q,
  output logic [CW-1:0]    count_q,
  output logic [AW-1:0]    base_a_q,
  output logic [AW-1:0]    base_b_q,
  output logic [AW-1:0]    per_base_q,
  output logic             start,
  output logic             dis_req,
  output logic             cfg_terr,
  output logic [NFLAG-1:0] clr_mask
);

  logic wr_ctrl, wr_cnt, wr_a, wr_b, wr_p, wr_clr;
  logic en_req, start_rej, cnt_rej;
  ctrl_t         ctrl_d;
  logic [CW-1:0] count_d;
  logic [AW-1:0] base_a_d, base_b_d, per_base_d;

  always_comb begin
    wr_ctrl = we && (sel == SEL_CTRL);
    wr_cnt  = we && (sel == SEL_COUNT);
    wr_a    = we && (sel == SEL_BASEA);
    wr_b    = we && (sel == SEL_BASEB);
    wr_p    = we && (sel == SEL_PBASE);
    wr_clr  = we && (sel == SEL_CLEAR);

    ctrl_d     = ctrl_q;
    count_d    = count_q;
    base_a_d   = base_a_q;
    base_b_d   = base_b_q;
    per_base_d = per_base_q;

    if (wr_ctrl && !active) ctrl_d = ctrl_t'(wdata[7:1]);
    if (wr_cnt && !active)  count_d = wdata[CW-1:0];
    // the base of the buffer not in use stays writable during a run
    if (wr_a && (!active || buf_sel))  base_a_d = wdata;
    if (wr_b && (!active || !buf_sel)) base_b_d = wdata;
    if (wr_p && !active)    per_base_d = wdata;

    en_req    = wr_ctrl && wdata[0] && !active;
    start_rej = en_req && !wdata[3] && (count_q == '0);
    start     = en_req && !start_rej;
    dis_req   = wr_ctrl && !wdata[0] && active;
    cnt_rej   = wr_cnt && active && (wdata[CW-1:0] == '0);
    cfg_terr  = start_rej || cnt_rej;
    clr_mask  = wr_clr ? wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      count_q    <= '0;
      base_a_q   <= '0;
      base_b_q   <= '0;
      per_base_q <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      count_q    <= count_d;
      base_a_q   <= base_a_d;
      base_b_q   <= base_b_d;
      per_base_q <= per_base_d;
    end
  end

endmodule

// File: rtl/dss_seq.sv
module dss_seq
  import dss_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dis_req,
  input  logic          bus_err,
  input  logic          item_done,
  input  logic          per_end,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] count_q,
  output logic          en_q,
  output logic [CW-1:0] rem_q,
  output logic          buf_q,
  output logic          buf_nxt,
  output logic          load,
  output logic          step,
  output logic          done_evt,
  output logic          half_evt,
  output logic          terr_evt
);

  logic          en_d, buf_d;
  logic [CW-1:0] rem_d, rem_dec, half_mark;

  always_comb begin
    en_d      = en_q;
    rem_d     = rem_q;
    buf_d     = buf_q;
    load      = 1'b0;
    step      = 1'b0;
    done_evt  = 1'b0;
    half_evt  = 1'b0;
    terr_evt  = 1'b0;
    rem_dec   = rem_q - 1'b1;
    half_mark = count_q >> 1;

    if (start) begin
      en_d  = 1'b1;
      rem_d = count_q;
      buf_d = 1'b0;
      load  = 1'b1;
    end else if (en_q) begin
      if (bus_err) begin
        en_d     = 1'b0;
        terr_evt = 1'b1;
      end else if (dis_req) begin
        en_d = 1'b0;
      end else if (ctrl.per_flow) begin
        if (per_end) begin
          en_d     = 1'b0;
          done_evt = 1'b1;
        end else if (item_done) begin
          step = 1'b1;
        end
      end else if (item_done) begin
        step     = 1'b1;
        half_evt = (rem_dec == half_mark);
        if (rem_q == {{(CW-1){1'b0}}, 1'b1}) begin
          done_evt = 1'b1;
          unique case (ctrl.mode)
            MODE_CIRC: begin
              rem_d = count_q;
              load  = 1'b1;
            end
            MODE_DBUF: begin
              rem_d = count_q;
              buf_d = ~buf_q;
              load  = 1'b1;
            end
            default: begin
              rem_d = '0;
              en_d  = 1'b0;
            end
          endcase
        end else begin
          rem_d = rem_dec;
        end
      end
    end
    buf_nxt = buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rem_q <= '0;
      buf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      rem_q <= rem_d;
      buf_q <= buf_d;
    end
  end

endmodule

// File: rtl/dss_ptr.sv
module dss_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          inc,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] stride, addr_d;

  always_comb begin
    unique case (size)
      2'd0:    stride = AW'(1);
      2'd1:    stride = AW'(2);
      default: stride = AW'(4);
    endcase
    addr_d = addr;
    if (load)              addr_d = base;
    else if (step && inc)  addr_d = addr + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end

endmodule

// File: rtl/dss_flags.sv
module dss_flags
  import dss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_mask,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags_q
);

  logic [NFLAG-1:0] flags_d;

  always_comb flags_d = (flags_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
  import dss_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          item_done,
  input  logic          per_end,
  input  logic          bus_err,
  input  logic          fifo_err,
  input  logic          dm_err,
  output logic          active,
  output logic          buf_sel,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] per_addr,
  output logic [CW-1:0] remaining,
  output logic [4:0]    flags,
  output logic          irq
);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ctrl_t            ctrl_q;
  logic [CW-1:0]    count_q;
  logic [AW-1:0]    base_a_q, base_b_q, per_base_q;
  logic             start, dis_req, cfg_terr;
  logic [NFLAG-1:0] clr_mask, set_mask;
  logic             seq_load, seq_step, buf_nxt;
  logic             done_evt, half_evt, terr_evt;
  logic [1:0]       mode_w;
  logic             flow_w;

  dss_cfg #(.AW(AW), .CW(CW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_ni),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .active     (active),
    .buf_sel    (buf_sel),
    .ctrl_q     (ctrl_q),
    .count_q    (count_q),
    .base_a_q   (base_a_q),
    .base_b_q   (base_b_q),
    .per_base_q (per_base_q),
    .start      (start),
    .dis_req    (dis_req),
    .cfg_terr   (cfg_terr),
    .clr_mask   (clr_mask)
  );

  dss_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start),
    .dis_req   (dis_req),
    .bus_err   (bus_err),
    .item_done (item_done),
    .per_end   (per_end),
    .ctrl      (ctrl_q),
    .count_q   (count_q),
    .en_q      (active),
    .rem_q     (remaining),
    .buf_q     (buf_sel),
    .buf_nxt   (buf_nxt),
    .load      (seq_load),
    .step      (seq_step),
    .done_evt  (done_evt),
    .half_evt  (half_evt),
    .terr_evt  (terr_evt)
  );

  logic [AW-1:0] ptr_base [NPTR];
  logic          ptr_inc  [NPTR];
  logic [AW-1:0] ptr_addr [NPTR];

  always_comb begin
    ptr_base[0] = buf_nxt ? base_b_q : base_a_q;
    ptr_inc[0]  = ctrl_q.minc;
    ptr_base[1] = per_base_q;
    ptr_inc[1]  = ctrl_q.pinc;
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dss_ptr #(.AW(AW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_ni),
      .load  (seq_load),
      .step  (seq_step),
      .inc   (ptr_inc[g]),
      .size  (ctrl_q.size),
      .base  (ptr_base[g]),
      .addr  (ptr_addr[g])
    );
  end

  assign mem_addr = ptr_addr[0];
  assign per_addr = ptr_addr[1];

  always_comb begin
    set_mask          = '0;
    set_mask[FL_HALF] = half_evt;
    set_mask[FL_DONE] = done_evt;
    set_mask[FL_TERR] = terr_evt || cfg_terr;
    set_mask[FL_FERR] = fifo_err;
    set_mask[FL_DERR] = dm_err;
  end

  dss_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_ni),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .flags_q  (flags)
  );

  assign irq    = |flags;
  assign mode_w = ctrl_q.mode;
  assign flow_w = ctrl_q.per_flow;

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          cfg_we,
  input logic          item_done,
  input logic          per_end,
  input logic          bus_err,
  input logic          active,
  input logic          buf_sel,
  input logic [CW-1:0] remaining,
  input logic [CW-1:0] count_q,
  input logic [4:0]    flags,
  input logic [1:0]    mode,
  input logic          per_flow
);

  logic dma_item;
  assign dma_item = active && !per_flow && item_done && !cfg_we && !bus_err;

  // R9: an active DMA-flow stream never holds a zero count
  a_r9_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    (active && !per_flow) |-> (remaining != '0));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_ni)
    (dma_item && remaining > 1) |=> (remaining == $past(remaining) - 1'b1));

  a_r4_normal_stop: assert property (@(posedge clk) disable iff (!rst_ni)
    (dma_item && remaining == 1 && (mode == 2'd0 || mode == 2'd3))
      |=> (!active && flags[1]));

  a_r5_circ_reload: assert property (@(posedge clk) disable iff (!rst_ni)
    (dma_item && remaining == 1 && mode == 2'd1)
      |=> (active && remaining == $past(count_q)));

  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_ni)
    (dma_item && remaining == 1 && mode == 2'd2)
      |=> (active && buf_sel != $past(buf_sel)));

  a_r8_per_end_stop: assert property (@(posedge clk) disable iff (!rst_ni)
    (active && per_flow && per_end && !cfg_we && !bus_err)
      |=> (!active && flags[1]));

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active && !cfg_we) |=> (!active && $stable(remaining)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cfg_we) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind dma_stream_seq dss_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .cfg_we    (cfg_we),
  .item_done (item_done),
  .per_end   (per_end),
  .bus_err   (bus_err),
  .active    (active),
  .buf_sel   (buf_sel),
  .remaining (remaining),
  .count_q   (count_q),
  .flags     (flags),
  .mode      (mode_w),
  .per_flow  (flow_w)
);

// File: tb/dma_stream_seq_test.sv
module dma_stream_seq_test;

  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          item_done, per_end, bus_err, fifo_err, dm_err;
  logic          active, buf_sel, irq;
  logic [AW-1:0] mem_addr, per_addr;
  logic [CW-1:0] remaining;
  logic [4:0]    flags;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  dma_stream_seq #(.AW(AW), .CW(CW)) uut (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .item_done, .per_end,
    .bus_err, .fifo_err, .dm_err, .active, .buf_sel, .mem_addr, .per_addr,
    .remaining, .flags, .irq
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] cnt;
    logic [7:0]  items;
    logic [15:0] rem;
    logic        act;
    logic        bsel;
    logic [31:0] mem;
    logic [31:0] per;
    logic [4:0]  flg;
  } vec_t;

  // control: b0 en, b2:1 mode, b3 flow, b5:4 size, b6 minc, b7 pinc
  localparam vec_t TBL [8] = '{
    '{8'h41, 16'd8, 8'd3, 16'd5, 1'b1, 1'b0, 32'h1003, 32'h4000_0000, 5'h00}, // R3 byte
    '{8'h61, 16'd8, 8'd4, 16'd4, 1'b1, 1'b0, 32'h1010, 32'h4000_0000, 5'h01}, // R3 R7 word
    '{8'h51, 16'd5, 8'd5, 16'd0, 1'b0, 1'b0, 32'h100A, 32'h4000_0000, 5'h03}, // R4 half-word
    '{8'h43, 16'd4, 8'd5, 16'd3, 1'b1, 1'b0, 32'h1001, 32'h4000_0000, 5'h03}, // R5 circular
    '{8'hE5, 16'd3, 8'd4, 16'd2, 1'b1, 1'b1, 32'h2004, 32'h4000_0004, 5'h03}, // R6 swap
    '{8'h45, 16'd2, 8'd4, 16'd2, 1'b1, 1'b0, 32'h1000, 32'h4000_0000, 5'h03}, // R6 two swaps
    '{8'hA1, 16'd6, 8'd2, 16'd4, 1'b1, 1'b0, 32'h1000, 32'h4000_0008, 5'h00}, // R3 fixed mem
    '{8'h41, 16'd1, 8'd1, 16'd0, 1'b0, 1'b0, 32'h1001, 32'h4000_0000, 5'h03}  // R7 count one
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic items(input int n);
    for (int i = 0; i < n; i++) begin
      item_done = 1'b1;
      @(negedge clk);
    end
    item_done = 1'b0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    item_done = 1'b0; per_end = 1'b0; bus_err = 1'b0; fifo_err = 1'b0; dm_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R14 reset state
    chk("R14 active", active, 0);
    chk("R14 remaining", remaining, 0);
    chk("R14 flags", flags, 0);
    chk("R14 irq", irq, 0);
    chk("R14 mem_addr", mem_addr, 0);
    chk("R14 buf_sel", buf_sel, 0);

    wr(3'd2, 32'h1000);
    wr(3'd3, 32'h2000);
    wr(3'd4, 32'h4000_0000);

    // R9 zero count on enable, R12 irq, R11 clear
    wr(3'd1, 0);
    wr(3'd0, 32'h01);
    chk("R9 enable zero stays idle", active, 0);
    chk("R9 enable zero terr", flags, 5'h04);
    chk("R12 irq on flag", irq, 1);
    wr(3'd5, 32'h04);
    chk("R11 w1c", flags, 0);
    chk("R12 irq clear", irq, 0);

    // R1 R2 R3 R4 R5 R6 R7: table walk
    foreach (TBL[k]) begin
      wr(3'd0, 0);
      wr(3'd5, 32'h1F);
      wr(3'd1, 32'(TBL[k].cnt));
      wr(3'd0, 32'(TBL[k].ctrl));
      if (k == 0) begin
        chk("R2 start remaining", remaining, 32'(TBL[k].cnt));
        chk("R2 start mem base", mem_addr, 32'h1000);
      end
      items(int'(TBL[k].items));
      chk($sformatf("R1 row%0d remaining", k), remaining, 32'(TBL[k].rem));
      chk($sformatf("R1 row%0d active", k), active, 32'(TBL[k].act));
      chk($sformatf("R1 row%0d buf_sel", k), buf_sel, 32'(TBL[k].bsel));
      chk($sformatf("R1 row%0d mem_addr", k), mem_addr, TBL[k].mem);
      chk($sformatf("R1 row%0d per_addr", k), per_addr, TBL[k].per);
      chk($sformatf("R1 row%0d flags", k), flags, 32'(TBL[k].flg));
    end

    // R9 zero count write while active
    wr(3'd0, 0);
    wr(3'd5, 32'h1F);
    wr(3'd1, 8);
    wr(3'd0, 32'h41);
    wr(3'd1, 0);
    chk("R9 zero write terr", flags, 5'h04);
    chk("R9 zero write still active", active, 1);
    chk("R9 zero write count kept", remaining, 8);

    // R13 items ignored while idle
    wr(3'd0, 0);
    items(2);
    chk("R13 idle remaining", remaining, 8);
    chk("R13 idle mem_addr", mem_addr, 32'h1000);

    // R8 peripheral flow
    wr(3'd5, 32'h1F);
    wr(3'd0, 32'h49);
    items(3);
    chk("R8 count held", remaining, 8);
    chk("R8 addr advances", mem_addr, 32'h1003);
    chk("R8 still active", active, 1);
    per_end = 1'b1; @(negedge clk); per_end = 1'b0;
    chk("R8 per_end stops", active, 0);
    chk("R8 per_end complete", flags, 5'h02);

    // R8 per_end ignored in DMA flow
    wr(3'd5, 32'h1F);
    wr(3'd0, 32'h41);
    per_end = 1'b1; @(negedge clk); per_end = 1'b0;
    chk("R8 dma flow ignores per_end", active, 1);
    chk("R8 dma flow no flag", flags, 0);

    // R10 errors
    bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
    chk("R10 bus_err stops", active, 0);
    chk("R10 bus_err terr", flags, 5'h04);
    fifo_err = 1'b1; @(negedge clk); fifo_err = 1'b0;
    chk("R10 fifo flag", flags, 5'h0C);
    dm_err = 1'b1; @(negedge clk); dm_err = 1'b0;
    chk("R10 direct flag", flags, 5'h1C);

    // R11 set wins over clear
    fifo_err = 1'b1;
    wr(3'd5, 32'h08);
    fifo_err = 1'b0;
    chk("R11 set over clear", flags, 5'h1C);
    wr(3'd5, 32'h1F);
    chk("R11 clear all", flags, 0);

    // R6 idle-buffer base write during a double-buffer run
    wr(3'd1, 2);
    wr(3'd0, 32'h45);
    wr(3'd3, 32'h3000);
    items(2);
    chk("R6 new base B used", mem_addr, 32'h3000);
    chk("R6 on buffer B", buf_sel, 1);
    wr(3'd3, 32'h5000);
    items(2);
    chk("R6 back to A", mem_addr, 32'h1000);
    items(2);
    chk("R6 in-use base write rejected", mem_addr, 32'h3000);

    finish_run();
  end

endmodule